// File: doc/BRIEF.md
# Switch Reset and Default-Configuration Sequencer

This block brings an Ethernet switch out of reset and loads its starting configuration. A start pulse begins a timed pattern on the reset pin. The pin is driven high, then pulled low, then driven high again. Each interval is a whole number of milliseconds, counted from a system clock with a configurable number of cycles per millisecond. During the low interval and the final high interval, the block drives the serial clock and data pins to fixed strap levels and holds chip select low. It releases those three pins once the final interval ends. The reset pin stays driven high after that.

The block then sends seven register writes, one at a time, to an external register master. Each write uses a request signal with an address and data, and waits for a one-cycle done pulse before the next write is issued. Six writes load the per-port configuration for ports 0 to 5, and the seventh turns on VLAN mode. A done flag then stays high until the next start pulse. A start pulse that arrives while a sequence is running is ignored.

Top module: `sw_boot_seq`

## Requirements
- R1: While `rst_n` is low and afterwards until `start`, all output enables, `wr_req` and `done` are 0.
- R2: After `start`, `rst_pin` is driven high (`rst_pin_oe`=1, `rst_pin`=1, straps not driven) for exactly HI_PRE_MS*CLK_PER_MS cycles.
- R3: `rst_pin` is then driven low for exactly LO_MS*CLK_PER_MS cycles.
- R4: `rst_pin` is then driven high again, with the straps still driven, for exactly HI_POST_MS*CLK_PER_MS cycles.
- R5: Throughout the low and final high intervals, `sck_oe`=1 with `sck`=1, `sdo_oe`=1 with `sdo`=0, and `csel_oe`=1 with `csel`=0.
- R6: After the final high interval, `sck_oe`, `sdo_oe` and `csel_oe` are 0, and `rst_pin` stays driven high.
- R7: The write addresses are 0x01, 0x03, 0x05, 0x07, 0x08, 0x09 (ports 0 to 5) and then 0x11, in this order. No other writes are issued.
- R8: The port writes carry 0x800F for ports 0 to 4 and 0x801F for port 5, where bit 4 is the tag enable. The 0x11 write carries 0xFF30.
- R9: `wr_req` stays high, with `wr_addr` and `wr_data` stable, until `wr_done` is seen. It then drops for at least one cycle before the next write.
- R10: After the seventh write is acknowledged, `done` goes to 1, with `wr_req` at 0, and stays there until the next `start`.
- R11: A `start` pulse during the reset intervals or the write burst has no effect on timing or on the writes.
- R12: A `start` pulse while `done` is 1 runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins the sequence |
| wr_done | input | 1 | One-cycle acknowledge of the pending write |
| rst_pin | output | 1 | Switch reset pin level |
| rst_pin_oe | output | 1 | Reset pin drive enable |
| sck | output | 1 | Serial clock pin level (strap) |
| sck_oe | output | 1 | Serial clock drive enable |
| sdo | output | 1 | Serial data pin level (strap) |
| sdo_oe | output | 1 | Serial data drive enable |
| csel | output | 1 | Chip select pin level |
| csel_oe | output | 1 | Chip select drive enable |
| wr_req | output | 1 | Register write request |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | DATA_W | Register write data |
| done | output | 1 | Sequence complete |

## Verification
The bench runs the sequence more than once. It measures the length of each reset interval in cycles and checks the strap levels on every cycle of those intervals. A register master model answers each request after a random delay. This shows that the write order and data do not depend on how quickly the master responds.

One run injects stray start pulses, once in the low interval and once in the middle of the write burst. Equal interval lengths and an unchanged seven-write list show that the pulses were ignored. A restart from the done state shows that a start pulse at that point is accepted.

// File: rtl/sw_boot_seq.sv
module sw_boot_seq #(
  parameter int CLK_PER_MS = 100000,
  parameter int HI_PRE_MS  = 20,
  parameter int LO_MS      = 100,
  parameter int HI_POST_MS = 30,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_done,
  output logic              rst_pin,
  output logic              rst_pin_oe,
  output logic              sck,
  output logic              sck_oe,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              csel,
  output logic              csel_oe,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done
);
  localparam int MAX_MS = (LO_MS > HI_PRE_MS) ? ((LO_MS > HI_POST_MS) ? LO_MS : HI_POST_MS)
                                              : ((HI_PRE_MS > HI_POST_MS) ? HI_PRE_MS : HI_POST_MS);
  localparam int CW = $clog2(CLK_PER_MS + 1);
  localparam int MW = $clog2(MAX_MS + 1);
  localparam int NWR = 7;
  localparam int IW = $clog2(NWR);
  localparam logic [CW-1:0] TICK_LAST = CW'(CLK_PER_MS - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(NWR - 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_LOW, S_POST, S_WR, S_DONE} st_t;

  st_t            st;
  logic [CW-1:0]  tick;
  logic [MW-1:0]  ms;
  logic [MW-1:0]  ms_last;
  logic [IW-1:0]  idx;
  logic           strap;
  logic           timed;

  assign strap      = (st == S_LOW) || (st == S_POST);
  assign timed      = (st == S_PRE) || strap;
  assign rst_pin_oe = (st != S_IDLE);
  assign rst_pin    = (st != S_LOW);
  assign sck_oe     = strap;
  assign sck        = strap;
  assign sdo_oe     = strap;
  assign sdo        = 1'b0;
  assign csel_oe    = strap;
  assign csel       = 1'b0;
  assign done       = (st == S_DONE);

  always_comb begin
    case (st)
      S_PRE:   ms_last = MW'(HI_PRE_MS - 1);
      S_LOW:   ms_last = MW'(LO_MS - 1);
      default: ms_last = MW'(HI_POST_MS - 1);
    endcase
  end

  always_comb begin
    case (idx)
      3'd0:    wr_addr = ADDR_W'(8'h01);
      3'd1:    wr_addr = ADDR_W'(8'h03);
      3'd2:    wr_addr = ADDR_W'(8'h05);
      3'd3:    wr_addr = ADDR_W'(8'h07);
      3'd4:    wr_addr = ADDR_W'(8'h08);
      3'd5:    wr_addr = ADDR_W'(8'h09);
      default: wr_addr = ADDR_W'(8'h11);
    endcase
    if (idx == IDX_LAST)   wr_data = DATA_W'(16'hFF30);
    else if (idx == 3'd5)  wr_data = DATA_W'(16'h801F);
    else                   wr_data = DATA_W'(16'h800F);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tick   <= '0;
      ms     <= '0;
      idx    <= '0;
      wr_req <= 1'b0;
    end else if (timed) begin
      if (tick == TICK_LAST) begin
        tick <= '0;
        if (ms == ms_last) begin
          ms <= '0;
          st <= (st == S_PRE) ? S_LOW : (st == S_LOW) ? S_POST : S_WR;
        end else begin
          ms <= ms + 1'b1;
        end
      end else begin
        tick <= tick + 1'b1;
      end
    end else if (st == S_WR) begin
      if (!wr_req) begin
        wr_req <= 1'b1;
      end else if (wr_done) begin
        wr_req <= 1'b0;
        if (idx == IDX_LAST) st <= S_DONE;
        else                 idx <= idx + 1'b1;
      end
    end else if (start) begin
      st   <= S_PRE;
      tick <= '0;
      ms   <= '0;
      idx  <= '0;
    end
  end

  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
  a_r9_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_req) |-> $past(wr_done));
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_req);
  a_r5_straps_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_pin) && rst_pin_oe) |-> (sck_oe && sck && sdo_oe && !sdo && csel_oe));
  a_r3_no_write_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pin_oe && !rst_pin) |-> !wr_req);
  a_r11_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOW && start) |=> (st == S_LOW || st == S_POST));
endmodule

// File: tb/sw_boot_seq_test.sv
module sw_boot_seq_test;
  localparam int CPM = 10, HPRE = 20, LOW = 100, HPOST = 30;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr_done = 1'b0;
  logic rst_pin, rst_pin_oe, sck, sck_oe, sdo, sdo_oe, csel, csel_oe, wr_req, done;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;

  int checks = 0, fails = 0, nw = 0, wait_cnt = 0;
  bit finished = 0;
  logic [7:0]  got_a [0:15];
  logic [15:0] got_d [0:15];

  always #5 clk = ~clk;

  sw_boot_seq #(.CLK_PER_MS(CPM), .HI_PRE_MS(HPRE), .LO_MS(LOW), .HI_POST_MS(HPOST)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_done(wr_done),
    .rst_pin(rst_pin), .rst_pin_oe(rst_pin_oe), .sck(sck), .sck_oe(sck_oe),
    .sdo(sdo), .sdo_oe(sdo_oe), .csel(csel), .csel_oe(csel_oe),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .done(done));

  function automatic logic [7:0] exp_addr(input int i);
    case (i)
      0: return 8'h01; 1: return 8'h03; 2: return 8'h05;
      3: return 8'h07; 4: return 8'h08; 5: return 8'h09;
      default: return 8'h11;
    endcase
  endfunction

  function automatic logic [15:0] exp_data(input int i);
    if (i == 6) return 16'hFF30;
    return (i == 5) ? 16'h801F : 16'h800F;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (wr_req && !wr_done) begin
      if (wait_cnt == 0) begin
        wr_done = 1'b1;
        if (nw < 16) begin got_a[nw] = wr_addr; got_d[nw] = wr_data; end
        nw++;
        wait_cnt = $urandom % 5;
      end else wait_cnt--;
    end else wr_done = 1'b0;
  end

  task automatic run_seq(input bit inj, input string tag);
    int n1 = 0, n2 = 0, n3 = 0, bad = 0, k = 0;
    bit injected = 0;
    nw = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (rst_pin_oe && rst_pin && !sck_oe) begin n1++; @(negedge clk); end
    while (rst_pin_oe && !rst_pin) begin
      n2++;
      if (!(sck_oe && sck && sdo_oe && !sdo && csel_oe && !csel)) bad++;
      start = (inj && n2 == 37);
      @(negedge clk);
    end
    start = 1'b0;
    while (rst_pin_oe && rst_pin && sck_oe) begin
      n3++;
      if (!(sck && sdo_oe && !sdo && csel_oe && !csel)) bad++;
      @(negedge clk);
    end
    chk(n1 == HPRE*CPM, {"R2 pre-high length ", tag}, n1, HPRE*CPM);
    chk(n2 == LOW*CPM, {"R3 low length (R11 if stray start) ", tag}, n2, LOW*CPM);
    chk(n3 == HPOST*CPM, {"R4 post-high length ", tag}, n3, HPOST*CPM);
    chk(bad == 0, {"R5 strap levels ", tag}, bad, 0);
    chk(rst_pin_oe && rst_pin && !sck_oe && !sdo_oe && !csel_oe, {"R6 pins released ", tag},
        {rst_pin_oe, rst_pin, sck_oe, sdo_oe, csel_oe}, 5'b11000);
    while (!done && k < 2000) begin
      if (inj && nw == 3 && !injected) begin start = 1'b1; injected = 1; end
      else start = 1'b0;
      if (wr_req && wr_done === 1'b0 && !rst_pin) bad++;
      @(negedge clk); k++;
    end
    start = 1'b0;
    chk(done && !wr_req, {"R10 done with no request ", tag}, {done, wr_req}, 2'b10);
    chk(nw == 7, {"R7 R11 write count ", tag}, nw, 7);
    for (int i = 0; i < 7 && i < nw; i++) begin
      chk(got_a[i] == exp_addr(i), {"R7 write address order ", tag}, got_a[i], exp_addr(i));
      chk(got_d[i] == exp_data(i), {"R8 write data ", tag}, got_d[i], exp_data(i));
    end
    repeat (8) @(negedge clk);
    chk(done && nw == 7 && rst_pin_oe && rst_pin, {"R10 done holds ", tag}, nw, 7);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!rst_pin_oe && !sck_oe && !sdo_oe && !csel_oe && !wr_req && !done, "R1 in reset",
        {rst_pin_oe, sck_oe, sdo_oe, csel_oe, wr_req, done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!rst_pin_oe && !wr_req && !done, "R1 idle before start", {rst_pin_oe, wr_req, done}, 0);
    run_seq(1'b1, "run1 with stray starts");
    run_seq(1'b0, "R12 restart from done");
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule